// File: doc/BRIEF.md
# Fast-Interrupt Source Selector

This block routes one interrupt source out of a set of 72 level-sensitive sources to a dedicated fast-interrupt output. A single control register holds a 7-bit source index and one enable bit. The fast-interrupt line follows the chosen source level combinationally whenever the enable bit is set.

The index space does not follow the natural bank order. The 32 sources of bank 1 come first, then the 32 sources of bank 2, then the 8 basic sources of bank 0. Software must mask a source on the normal interrupt path before it selects that source here. If it does not, the source raises both the normal and the fast interrupt. Normal interrupt masking and status collection are handled by a neighbouring block.

Top module: `fiq_route_sel`

## Requirements
- R1: After reset the control register reads 0 at offset 0x0c, and `fiqOut` is low even when every source is high.
- R2: A write to byte offset 0x0c loads bits 6:0 as the source index and bit 7 as the enable bit. The new value reads back from the cycle after the write edge. A read in the same cycle as the write returns the old value.
- R3: Bits 31:8 of the control register always read 0. Ones written to those bits have no effect.
- R4: A write to any offset other than 0x0c leaves the control register unchanged, and a read at any other offset returns 0.
- R5: With the enable bit set, indices 0 to 31 drive `fiqOut` from `bank1Src[index]`.
- R6: With the enable bit set, indices 32 to 63 drive `fiqOut` from `bank2Src[index-32]`.
- R7: With the enable bit set, indices 64 to 71 drive `fiqOut` from `bank0Src[index-64]`.
- R8: Indices 72 to 127 select no source, and `fiqOut` stays low for them.
- R9: With the enable bit clear, `fiqOut` is low whatever the index and the source levels.
- R10: `fiqOut` follows a change of the selected source in the same cycle, with no register in the path. Unselected sources have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset for the write and the read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| bank1Src | input | 32 | Bank 1 source levels, index 0..31 |
| bank2Src | input | 32 | Bank 2 source levels, index 32..63 |
| bank0Src | input | 8 | Bank 0 basic source levels, index 64..71 |
| fiqOut | output | 1 | Fast-interrupt output |

## Verification
Two functions can land in the same cycle: a register write that changes the selection, and a read or a source-level change seen under the old selection. The bench drives a write and samples `regRdData` and `fiqOut` before the clock edge. It expects the old register value and the old source routing. After the edge it expects the new ones. Source toggles on selected and unselected lines, made without any clock edge, check that only the selected line reaches `fiqOut` and that it does so at once.

// File: rtl/fiq_sel_pkg.sv
package fiq_sel_pkg;
  localparam int B1_N  = 32;
  localparam int B2_N  = 32;
  localparam int B0_N  = 8;
  localparam int SRC_N = B1_N + B2_N + B0_N;
  localparam int IDX_W = $clog2(SRC_N);

  // strobes from the register decoder to the selection datapath
  typedef struct packed {
    logic             load;
    logic             enable;
    logic [IDX_W-1:0] index;
  } ctrlStrobe_t;
endpackage

// File: rtl/fiq_sel_ctrl.sv
module fiq_sel_ctrl
  import fiq_sel_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFF = 'h0c
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W:0]    wrLow,
  output ctrlStrobe_t       strobe,
  output logic              rdHit
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CTRL_OFF);

  logic addrHit;

  always_comb begin
    addrHit       = (addr == OFF);
    rdHit         = addrHit;
    strobe.load   = wrEn && addrHit;
    strobe.enable = wrLow[IDX_W];
    strobe.index  = wrLow[IDX_W-1:0];
  end

  // R4
  load_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (wrEn && addr == OFF));
endmodule

// File: rtl/fiq_sel_dp.sv
module fiq_sel_dp
  import fiq_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [B1_N-1:0] bank1Src,
  input  logic [B2_N-1:0] bank2Src,
  input  logic [B0_N-1:0] bank0Src,
  output logic [IDX_W:0]  ctrlView,
  output logic            fiqOut
);
  logic             enReg;
  logic [IDX_W-1:0] idxReg;
  logic [SRC_N-1:0] allSrc;
  logic [SRC_N-1:0] lineHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      idxReg <= '0;
    end else if (strobe.load) begin
      enReg  <= strobe.enable;
      idxReg <= strobe.index;
    end
  end

  // index order: bank 1, then bank 2, then bank 0
  assign allSrc = {bank0Src, bank2Src, bank1Src};

  for (genvar i = 0; i < SRC_N; i++) begin : g_line
    assign lineHit[i] = (idxReg == IDX_W'(i)) && allSrc[i];
  end

  assign fiqOut   = enReg && (|lineHit);
  assign ctrlView = {enReg, idxReg};

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> !fiqOut);
  // R8
  no_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxReg >= IDX_W'(SRC_N)) |-> !fiqOut);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (ctrlView == $past({strobe.enable, strobe.index})));
  // R5
  bank1_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && idxReg < IDX_W'(B1_N)) |-> (fiqOut == bank1Src[idxReg[$clog2(B1_N)-1:0]]));
endmodule

// File: rtl/fiq_route_sel.sv
module fiq_route_sel
  import fiq_sel_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFF = 'h0c
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [B1_N-1:0]   bank1Src,
  input  logic [B2_N-1:0]   bank2Src,
  input  logic [B0_N-1:0]   bank0Src,
  output logic              fiqOut
);
  localparam int VIEW_W = IDX_W + 1;

  ctrlStrobe_t       strobe;
  logic              rdHit;
  logic [VIEW_W-1:0] ctrlView;

  fiq_sel_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrLow(regWrData[VIEW_W-1:0]), .strobe(strobe), .rdHit(rdHit)
  );

  fiq_sel_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bank1Src(bank1Src), .bank2Src(bank2Src), .bank0Src(bank0Src),
    .ctrlView(ctrlView), .fiqOut(fiqOut)
  );

  assign regRdData = rdHit ? {{(DATA_W-VIEW_W){1'b0}}, ctrlView} : '0;

  // R3
  upper_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(CTRL_OFF) && (|regWrData[DATA_W-1:VIEW_W]))
      |=> (regRdData[DATA_W-1:VIEW_W] == '0));
  // R4
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != ADDR_W'(CTRL_OFF)) |=> $stable(ctrlView));
endmodule

// File: tb/fiq_route_sel_test.sv
`timescale 1ns/1ps
module fiq_route_sel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h0c;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] bank1Src = '0;
  logic [31:0] bank2Src = '0;
  logic [7:0]  bank0Src = '0;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          isRead;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t scoreQ[$];
  event  chkEv;

  always #5 clk = ~clk;

  fiq_route_sel uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bank1Src(bank1Src),
    .bank2Src(bank2Src), .bank0Src(bank0Src), .fiqOut(fiqOut)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chkEv);
      while (scoreQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = scoreQ.pop_front();
        act = it.isRead ? regRdData : {31'b0, fiqOut};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: %s actual=%h expected=%h", it.req,
                   it.isRead ? "read" : "fiq", act, it.exp);
        end
      end
    end
  end

  task automatic expFiq(input logic v, input string req);
    #1;
    scoreQ.push_back('{isRead: 1'b0, exp: {31'b0, v}, req: req});
    ->chkEv;
    #1;
  endtask

  task automatic expRd(input logic [7:0] a, input logic [31:0] v, input string req);
    regAddr = a;
    #1;
    scoreQ.push_back('{isRead: 1'b1, exp: v, req: req});
    ->chkEv;
    #1;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h0c;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    bank1Src = '1; bank2Src = '1; bank0Src = '1;
    expRd(8'h0c, 32'h0, "R1");
    expFiq(1'b0, "R1");
    bank1Src = '0; bank2Src = '0; bank0Src = '0;

    // R2 / R10 enable with index 5
    writeReg(8'h0c, 32'h85);
    expRd(8'h0c, 32'h85, "R2");
    bank1Src[5] = 1'b1; expFiq(1'b1, "R10");
    bank1Src[5] = 1'b0; expFiq(1'b0, "R10");
    bank1Src = 32'hFFFF_FFDF; expFiq(1'b0, "R10");
    bank1Src = '0;

    // R5 top of bank 1
    writeReg(8'h0c, 32'h80 | 31);
    bank1Src[31] = 1'b1; expFiq(1'b1, "R5");
    bank1Src = '0;

    // R6 bank 2 bounds
    writeReg(8'h0c, 32'h80 | 32);
    bank1Src[0] = 1'b1; expFiq(1'b0, "R6");
    bank2Src[0] = 1'b1; expFiq(1'b1, "R6");
    bank1Src = '0; bank2Src = '0;
    writeReg(8'h0c, 32'h80 | 63);
    bank2Src[31] = 1'b1; expFiq(1'b1, "R6");
    bank2Src = '0;

    // R7 bank 0 bounds
    writeReg(8'h0c, 32'h80 | 64);
    bank0Src[0] = 1'b1; expFiq(1'b1, "R7");
    bank0Src = '0;
    writeReg(8'h0c, 32'h80 | 71);
    bank0Src = 8'h7f; expFiq(1'b0, "R7");
    bank0Src[7] = 1'b1; expFiq(1'b1, "R7");

    // R8 out-of-range indices
    bank1Src = '1; bank2Src = '1; bank0Src = '1;
    writeReg(8'h0c, 32'h80 | 72);
    expFiq(1'b0, "R8");
    writeReg(8'h0c, 32'hFF);
    expFiq(1'b0, "R8");

    // R9 enable clear
    writeReg(8'h0c, 32'h05);
    expFiq(1'b0, "R9");
    expRd(8'h0c, 32'h05, "R9");

    // R3 upper bits
    writeReg(8'h0c, 32'hFFFF_FF85);
    expRd(8'h0c, 32'h85, "R3");
    expFiq(1'b1, "R3");

    // R4 foreign offset
    writeReg(8'h10, 32'h02);
    expRd(8'h0c, 32'h85, "R4");
    expRd(8'h10, 32'h0, "R4");
    expRd(8'h00, 32'h0, "R4");

    // R2 same-cycle write: old value and old routing before the edge
    bank1Src = '0; bank1Src[5] = 1'b1; bank2Src = '0; bank0Src = '0;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h0c; regWrData = 32'h80 | 33;
    #1;
    scoreQ.push_back('{isRead: 1'b1, exp: 32'h85, req: "R2"});
    scoreQ.push_back('{isRead: 1'b0, exp: 32'h1, req: "R2"});
    ->chkEv;
    @(negedge clk);
    regWrEn = 1'b0;
    expRd(8'h0c, 32'hA1, "R2");
    expFiq(1'b0, "R2");
    bank2Src[1] = 1'b1; expFiq(1'b1, "R6");

    #20;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule